// File: doc/BRIEF.md
# Multicast Stream Router

This block joins one source stream to up to four consumers: the host output stream, a hash snoop port, a math engine input and a seed store. A 4-bit route select picks the consumers. Each select bit enables one consumer: bit 0 is the host output, bit 1 the hash snoop, bit 2 the math engine and bit 3 the seed store. The block holds no storage, so every output is a function of the inputs in the same cycle.

When several consumers are selected, a beat moves only when all of them are ready. Each consumer sees valid only when the beat is going to be taken by every selected consumer. This lets an incoming ciphertext stream be copied to a hash engine while the math engine decodes it, and it needs no skid buffer. Seeds can move between the math side and the seed store without using the host bus.

The hash snoop exists only to copy a stream that the engine is decoding. A select that sets the snoop bit without the engine bit is therefore refused. The legal codes are held in a parameter table.

Top module: `mcast_stream_router`

## Requirements
- R1: `src_ready` is 1 exactly when at least one consumer is enabled and every enabled consumer's ready is 1. With no consumer enabled it is 0.
- R2: An enabled consumer's valid equals `src_valid` ANDed with the ready of every other enabled consumer. The consumer's own ready does not affect its own valid.
- R3: A consumer whose select bit is 0 sees valid 0, data all zero and last 0.
- R4: An enabled consumer receives `src_data` and `src_last` unchanged.
- R5: The select codes 2, 3, 10 and 11 (snoop bit 1 set with engine bit 2 clear) are illegal. For these codes `route_illegal` is 1, every consumer valid is 0, every consumer's data and last are zero, and `src_ready` is 0. For all other codes `route_illegal` is 0.
- R6: In any cycle where `src_valid` and `src_ready` are both 1, every enabled consumer sees valid and ready both 1. No consumer sees valid and ready both 1 unless the source handshake also completes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| route_sel | input | 4 | Consumer enable mask: bit0 host, bit1 snoop, bit2 engine, bit3 seed store |
| route_illegal | output | 1 | Select names an illegal combination |
| src_valid | input | 1 | Source beat valid |
| src_ready | output | 1 | Source beat accepted |
| src_data | input | DATA_W | Source beat data |
| src_last | input | 1 | Source end-of-packet marker |
| host_valid | output | 1 | Host output stream valid |
| host_ready | input | 1 | Host output stream ready |
| host_data | output | DATA_W | Host output data |
| host_last | output | 1 | Host output end marker |
| snoop_valid | output | 1 | Hash snoop valid |
| snoop_ready | input | 1 | Hash snoop ready |
| snoop_data | output | DATA_W | Hash snoop data |
| snoop_last | output | 1 | Hash snoop end marker |
| eng_valid | output | 1 | Math engine valid |
| eng_ready | input | 1 | Math engine ready |
| eng_data | output | DATA_W | Math engine data |
| eng_last | output | 1 | Math engine end marker |
| seed_valid | output | 1 | Seed store valid |
| seed_ready | input | 1 | Seed store ready |
| seed_data | output | DATA_W | Seed store data |
| seed_last | output | 1 | Seed store end marker |

## Verification
Multicast delivery and backpressure can occur in the same cycle. While the engine and the snoop port both take a beat, either of them may stall, and the stall must hold back the beat for the other consumer as well as for the source. The bench covers this case by sweeping every route code against all sixteen ready patterns, with source valid and last both high and low. For each vector it compares every consumer's valid, the data and `src_ready` with values it computes from the enable mask. It also checks that a stalled consumer never leaves a partner with a one-sided handshake.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int unsigned NUM_DST = 4;
  localparam int unsigned SEL_W   = NUM_DST;
  localparam int unsigned NUM_CODES = 1 << SEL_W;

  typedef enum int unsigned {
    DST_HOST   = 0,
    DST_SNOOP  = 1,
    DST_ENGINE = 2,
    DST_SEED   = 3
  } dst_idx_e;

  // A code is refused when the snoop bit is set and the engine bit is clear.
  localparam logic [NUM_CODES-1:0] LEGAL_DEFAULT = 16'hF3F3;
endpackage

// File: rtl/mcr_route_decode.sv
module mcr_route_decode #(
  parameter int unsigned SEL_W = 4,
  parameter logic [(1<<SEL_W)-1:0] LEGAL_MAP = '1
) (
  input  logic [SEL_W-1:0] sel,
  output logic [SEL_W-1:0] enable,
  output logic             illegal
);
  always_comb begin
    illegal = ~LEGAL_MAP[sel];
    enable  = illegal ? '0 : sel;
  end
endmodule

// File: rtl/mcr_ready_join.sv
module mcr_ready_join #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] enable,
  input  logic [N-1:0] ready,
  output logic         all_ready,
  output logic [N-1:0] others_ready
);
  localparam logic [N-1:0] ONE = 1;

  logic [N-1:0] clear;
  assign clear     = ready | ~enable;
  assign all_ready = (|enable) & (&clear);

  for (genvar i = 0; i < N; i++) begin : g_excl
    assign others_ready[i] = &(clear | (ONE << i));
  end
endmodule

// File: rtl/mcr_lane.sv
module mcr_lane #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              enable,
  input  logic              src_valid,
  input  logic              others_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_last,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data,
  output logic              dst_last
);
  always_comb begin
    dst_valid = src_valid & enable & others_ready;
    dst_data  = enable ? src_data : '0;
    dst_last  = enable & src_last;
  end
endmodule

// File: rtl/mcast_stream_router.sv
module mcast_stream_router
  import mcr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [NUM_CODES-1:0] LEGAL_MAP = LEGAL_DEFAULT
) (
  input  logic [SEL_W-1:0]  route_sel,
  output logic              route_illegal,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_last,
  output logic              host_valid,
  input  logic              host_ready,
  output logic [DATA_W-1:0] host_data,
  output logic              host_last,
  output logic              snoop_valid,
  input  logic              snoop_ready,
  output logic [DATA_W-1:0] snoop_data,
  output logic              snoop_last,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [DATA_W-1:0] eng_data,
  output logic              eng_last,
  output logic              seed_valid,
  input  logic              seed_ready,
  output logic [DATA_W-1:0] seed_data,
  output logic              seed_last
);
  logic [NUM_DST-1:0] enable;
  logic [NUM_DST-1:0] dst_ready;
  logic [NUM_DST-1:0] others_ready;
  logic [NUM_DST-1:0] dst_valid;
  logic [NUM_DST-1:0] dst_last;
  logic [DATA_W-1:0]  dst_data [NUM_DST];

  assign dst_ready[DST_HOST]   = host_ready;
  assign dst_ready[DST_SNOOP]  = snoop_ready;
  assign dst_ready[DST_ENGINE] = eng_ready;
  assign dst_ready[DST_SEED]   = seed_ready;

  mcr_route_decode #(.SEL_W(SEL_W), .LEGAL_MAP(LEGAL_MAP)) u_decode (
    .sel     (route_sel),
    .enable  (enable),
    .illegal (route_illegal)
  );

  mcr_ready_join #(.N(NUM_DST)) u_join (
    .enable       (enable),
    .ready        (dst_ready),
    .all_ready    (src_ready),
    .others_ready (others_ready)
  );

  for (genvar i = 0; i < NUM_DST; i++) begin : g_lane
    mcr_lane #(.DATA_W(DATA_W)) u_lane (
      .enable       (enable[i]),
      .src_valid    (src_valid),
      .others_ready (others_ready[i]),
      .src_data     (src_data),
      .src_last     (src_last),
      .dst_valid    (dst_valid[i]),
      .dst_data     (dst_data[i]),
      .dst_last     (dst_last[i])
    );
  end

  assign host_valid  = dst_valid[DST_HOST];
  assign host_data   = dst_data[DST_HOST];
  assign host_last   = dst_last[DST_HOST];
  assign snoop_valid = dst_valid[DST_SNOOP];
  assign snoop_data  = dst_data[DST_SNOOP];
  assign snoop_last  = dst_last[DST_SNOOP];
  assign eng_valid   = dst_valid[DST_ENGINE];
  assign eng_data    = dst_data[DST_ENGINE];
  assign eng_last    = dst_last[DST_ENGINE];
  assign seed_valid  = dst_valid[DST_SEED];
  assign seed_data   = dst_data[DST_SEED];
  assign seed_last   = dst_last[DST_SEED];
endmodule

// File: rtl/mcast_stream_router_chk.sv
module mcast_stream_router_chk (
  input logic [3:0] route_sel,
  input logic       route_illegal,
  input logic       src_valid,
  input logic       src_ready,
  input logic [3:0] v,
  input logic [3:0] r
);
  always_comb begin
    // R6: a completed source beat reaches every selected consumer
    if (src_valid && src_ready) begin
      p_all_take_r6: assert ((v & r & route_sel) == route_sel);
    end
    // R6: no consumer handshake without the source handshake
    if ((v & r) != 4'b0) begin
      p_no_orphan_r6: assert (src_valid && src_ready);
    end
    // R5: an illegal route is fully quiet
    if (route_illegal) begin
      p_illegal_quiet_r5: assert (!src_ready && v == 4'b0);
    end
    // R3: valid only on selected consumers
    p_unsel_quiet_r3: assert ((v & ~route_sel) == 4'b0);
    // R1: nothing selected means no ready
    if (route_sel == 4'b0) begin
      p_idle_no_ready_r1: assert (!src_ready);
    end
  end
endmodule

bind mcast_stream_router mcast_stream_router_chk u_chk (
  .route_sel     (route_sel),
  .route_illegal (route_illegal),
  .src_valid     (src_valid),
  .src_ready     (src_ready),
  .v             ({seed_valid, eng_valid, snoop_valid, host_valid}),
  .r             ({seed_ready, eng_ready, snoop_ready, host_ready})
);

// File: tb/mcast_stream_router_tb.sv
module mcast_stream_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]    route_sel = '0;
  logic          route_illegal;
  logic          src_valid = 1'b0, src_ready, src_last = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic          host_valid, snoop_valid, eng_valid, seed_valid;
  logic          host_ready = 1'b0, snoop_ready = 1'b0, eng_ready = 1'b0, seed_ready = 1'b0;
  logic [DW-1:0] host_data, snoop_data, eng_data, seed_data;
  logic          host_last, snoop_last, eng_last, seed_last;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int cyc = 0;

  mcast_stream_router u_dut (
    .route_sel(route_sel), .route_illegal(route_illegal),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data), .src_last(src_last),
    .host_valid(host_valid), .host_ready(host_ready), .host_data(host_data), .host_last(host_last),
    .snoop_valid(snoop_valid), .snoop_ready(snoop_ready), .snoop_data(snoop_data), .snoop_last(snoop_last),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_data(eng_data), .eng_last(eng_last),
    .seed_valid(seed_valid), .seed_ready(seed_ready), .seed_data(seed_data), .seed_last(seed_last)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (sel=%0d rdy=%b v=%b)",
               req, act, exp, route_sel,
               {seed_ready, eng_ready, snoop_ready, host_ready}, src_valid);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // reset state: all inputs low
    #(CLK_PERIOD/2 + 1);
    chk(src_ready == 1'b0, "R1 idle ready", src_ready, 0);
    chk({seed_valid, eng_valid, snoop_valid, host_valid} == 4'b0, "R3 idle valid",
        {seed_valid, eng_valid, snoop_valid, host_valid}, 0);
    chk(route_illegal == 1'b0, "R5 idle flag", route_illegal, 0);

    for (int s = 0; s < 16; s++) begin
      for (int rdy = 0; rdy < 16; rdy++) begin
        for (int vl = 0; vl < 4; vl++) begin
          logic [3:0] sel, rv, en, clr, ev, act_v;
          logic ill, er;
          logic [DW-1:0] d;
          logic [DW-1:0] act_d [4];
          logic [3:0] act_l;
          sel = 4'(s); rv = 4'(rdy);
          d = 32'hC0DE0000 ^ (DW'(s) << 8) ^ DW'(rdy) ^ (DW'(vl) << 4);
          @(negedge clk);
          route_sel = sel; src_valid = vl[0]; src_last = vl[1]; src_data = d;
          {seed_ready, eng_ready, snoop_ready, host_ready} = rv;
          #1;
          ill = sel[1] && !sel[2];
          en  = ill ? 4'b0 : sel;
          clr = rv | ~en;
          er  = (en != 0) && (clr == 4'hF);
          for (int i = 0; i < 4; i++) begin
            logic [3:0] m;
            m = clr; m[i] = 1'b1;
            ev[i] = vl[0] && en[i] && (m == 4'hF);
          end
          act_v = {seed_valid, eng_valid, snoop_valid, host_valid};
          act_d[0] = host_data; act_d[1] = snoop_data; act_d[2] = eng_data; act_d[3] = seed_data;
          act_l = {seed_last, eng_last, snoop_last, host_last};
          chk(src_ready == er, "R1 src_ready", src_ready, er);
          chk(route_illegal == ill, "R5 illegal flag", route_illegal, ill);
          chk((act_v & en) == (ev & en), "R2 selected valid", act_v & en, ev & en);
          chk((act_v & ~en) == 4'b0, "R3 unselected valid", act_v & ~en, 0);
          for (int i = 0; i < 4; i++) begin
            logic [DW-1:0] xd;
            logic xl;
            xd = en[i] ? d : '0;
            xl = en[i] & vl[1];
            if (en[i]) begin
              chk(act_d[i] == xd && act_l[i] == xl, "R4 pass-through", {act_l[i], act_d[i]}, {xl, xd});
            end else begin
              chk(act_d[i] == xd && act_l[i] == xl, "R3 unselected data", {act_l[i], act_d[i]}, {xl, xd});
            end
          end
          if (ill) chk(act_v == 4'b0 && !src_ready, "R5 illegal quiet", {src_ready, act_v}, 0);
          if (vl[0] && er)
            chk(((act_v & rv) & en) == en, "R6 beat to all", act_v & rv, en);
          chk(((act_v & rv) == 4'b0) || (vl[0] && src_ready), "R6 no orphan handshake",
              act_v & rv, 0);
        end
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule